// File: doc/BRIEF.md
# Bidirectional Shift and Rotate Unit

This block is a purely combinational word shifter. It takes a data word, a three-bit operation selector and a signed shift count, and returns the word moved left or right, or rotated. The operations are logical, arithmetic or circular, in either direction. The data width is a parameter. There is no clock, and the result follows the inputs within the same cycle.

A negative count reverses the direction of whichever operation is selected. Rotating left by -1 is therefore rotating right by 1, and shifting arithmetic-left by -2 is shifting arithmetic-right by 2.

For a left arithmetic shift, the bits that enter at the bottom are copies of the input's lowest bit. For a right arithmetic shift, the bits that enter at the top are copies of the input's highest bit. A logical shift always brings in zeros.

Internally, a decoder turns the selector and count into a kind, a direction and a magnitude. One core handles the filled shifts and another handles the rotates. The top picks between the two results.

Top module: `shf_unit`

## Requirements
- R1: Selector 000 shifts left and fills the vacated low bits with 0 (1001010 by 2 gives 0101000).
- R2: Selector 001 shifts right and fills the vacated high bits with 0 (1001010 by 4 gives 0000100).
- R3: Selector 010 shifts left and fills the vacated low bits with copies of the input's bit 0 (1001010 by 2 gives 0101000).
- R4: Selector 011 shifts right and fills the vacated high bits with copies of the input's bit WIDTH-1 (1001010 by 4 gives 1111100).
- R5: Selector 100 rotates left, and bits leaving the top re-enter at bit 0 (1001010 by 2 gives 0101010).
- R6: Selector 101 rotates right, and bits leaving bit 0 re-enter at the top (1001010 by 1 gives 0100101).
- R7: A negative two's-complement count applies the opposite-direction operation of the same kind, by the count's magnitude.
- R8: For selectors 000 to 011, a magnitude of WIDTH or more gives a word made only of fill bits.
- R9: For selectors 100 and 101, the magnitude is taken modulo WIDTH, so the number of ones never changes.
- R10: A count of zero returns the input unchanged for every selector.
- R11: Selectors 110 and 111 return the input unchanged for any count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_in | input | WIDTH | Word to be shifted or rotated |
| op_code | input | 3 | Operation selector. Bits [2:1] give the kind (00 logical, 01 arithmetic, 10 rotate, 11 pass). Bit 0 gives the direction (0 left, 1 right). |
| shift_amt | input | AMT_W | Signed count. The default width is $clog2(WIDTH)+2. |
| data_out | output | WIDTH | Result |

## Verification
The unit is driven through every data word of the 7-bit width, against every selector and every count from -16 to +15.

That sweep separates three things:
- the in-range moves, from the fill-only results beyond WIDTH;
- the modulo wrap of rotates, from the saturation of shifts;
- negative counts, which must match the opposite operation.

Words with bit 0 or bit 6 set show whether the arithmetic fill copies the correct end bit. The worked examples with 1001010 are also checked as fixed literal values.

// File: rtl/shf_pkg.sv
package shf_pkg;

    typedef enum logic [2:0] {
        OP_LSL    = 3'b000,
        OP_LSR    = 3'b001,
        OP_ASL    = 3'b010,
        OP_ASR    = 3'b011,
        OP_ROL    = 3'b100,
        OP_ROR    = 3'b101,
        OP_PASS_A = 3'b110,
        OP_PASS_B = 3'b111
    } shf_op_e;

    typedef enum logic [1:0] {
        KIND_LOGIC = 2'b00,
        KIND_ARITH = 2'b01,
        KIND_ROT   = 2'b10,
        KIND_PASS  = 2'b11
    } shf_kind_e;

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode
    import shf_pkg::*;
#(
    parameter int AMT_W = 5
) (
    input  logic [2:0]             op_code,
    input  logic signed [AMT_W-1:0] shift_amt,
    output shf_kind_e              kind,
    output logic                   go_right,
    output logic [AMT_W-1:0]       mag
);

    logic neg;

    assign neg      = shift_amt[AMT_W-1];
    // Magnitude of the most negative count still fits as an unsigned value.
    assign mag      = neg ? (~shift_amt + AMT_W'(1)) : shift_amt;
    assign go_right = op_code[0] ^ neg;
    assign kind     = shf_kind_e'(op_code[2:1]);

endmodule

// File: rtl/shf_shift_core.sv
module shf_shift_core #(
    parameter int WIDTH = 7,
    parameter int AMT_W = 5
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic             go_right,
    input  logic             arith,
    input  logic [AMT_W-1:0] mag,
    output logic [WIDTH-1:0] data_out
);

    localparam int EXT_W = 2 * WIDTH;

    logic             fill;
    logic             full;
    logic [EXT_W-1:0] ext_l;
    logic [EXT_W-1:0] ext_r;
    logic [EXT_W-1:0] mov_l;
    logic [EXT_W-1:0] mov_r;

    assign fill  = arith & (go_right ? data_in[WIDTH-1] : data_in[0]);
    assign full  = (32'(mag) >= WIDTH);
    assign ext_l = {data_in, {WIDTH{fill}}};
    assign ext_r = {{WIDTH{fill}}, data_in};
    assign mov_l = ext_l << mag;
    assign mov_r = ext_r >> mag;

    always_comb begin
        if (full) begin
            data_out = {WIDTH{fill}};
        end else if (go_right) begin
            data_out = mov_r[WIDTH-1:0];
        end else begin
            data_out = mov_l[EXT_W-1:WIDTH];
        end
    end

endmodule

// File: rtl/shf_rotate_core.sv
module shf_rotate_core #(
    parameter int WIDTH = 7,
    parameter int AMT_W = 5
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic             go_right,
    input  logic [AMT_W-1:0] mag,
    output logic [WIDTH-1:0] data_out
);

    localparam int EXT_W = 2 * WIDTH;

    logic [AMT_W-1:0] rot;
    logic [EXT_W-1:0] dbl;
    logic [EXT_W-1:0] mov_l;
    logic [EXT_W-1:0] mov_r;

    assign rot   = AMT_W'(32'(mag) % WIDTH);
    assign dbl   = {data_in, data_in};
    assign mov_l = dbl << rot;
    assign mov_r = dbl >> rot;

    always_comb begin
        if (go_right) begin
            data_out = mov_r[WIDTH-1:0];
        end else begin
            data_out = mov_l[EXT_W-1:WIDTH];
        end
    end

endmodule

// File: rtl/shf_unit.sv
module shf_unit
    import shf_pkg::*;
#(
    parameter int WIDTH = 7,
    parameter int AMT_W = $clog2(WIDTH) + 2
) (
    input  logic [WIDTH-1:0]        data_in,
    input  logic [2:0]              op_code,
    input  logic signed [AMT_W-1:0] shift_amt,
    output logic [WIDTH-1:0]        data_out
);

    shf_kind_e        kind;
    logic             go_right;
    logic [AMT_W-1:0] mag;
    logic [WIDTH-1:0] shift_res;
    logic [WIDTH-1:0] rot_res;

    shf_amount_decode #(.AMT_W(AMT_W)) u_dec (
        .op_code   (op_code),
        .shift_amt (shift_amt),
        .kind      (kind),
        .go_right  (go_right),
        .mag       (mag)
    );

    shf_shift_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_shift (
        .data_in  (data_in),
        .go_right (go_right),
        .arith    (kind == KIND_ARITH),
        .mag      (mag),
        .data_out (shift_res)
    );

    shf_rotate_core #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_rot (
        .data_in  (data_in),
        .go_right (go_right),
        .mag      (mag),
        .data_out (rot_res)
    );

    always_comb begin
        unique case (kind)
            KIND_LOGIC, KIND_ARITH: data_out = shift_res;
            KIND_ROT:               data_out = rot_res;
            default:                data_out = data_in;
        endcase
    end

endmodule

// File: rtl/shf_unit_chk.sv
module shf_unit_chk #(
    parameter int WIDTH = 7,
    parameter int AMT_W = 5
) (
    input logic [WIDTH-1:0]        data_in,
    input logic [2:0]              op_code,
    input logic signed [AMT_W-1:0] shift_amt,
    input logic [WIDTH-1:0]        data_out
);

    int amt_i;
    int amt_abs;

    always_comb begin
        amt_i   = int'(shift_amt);
        amt_abs = (amt_i < 0) ? -amt_i : amt_i;

        p_zero_amt_r10: assert (amt_i != 0 || data_out == data_in);
        p_pass_r11:     assert (op_code[2:1] != 2'b11 || data_out == data_in);
        p_rot_weight_r9: assert (op_code[2:1] != 2'b10
                                 || $countones(data_out) == $countones(data_in));
        p_logic_sat_r8: assert (op_code[2:1] != 2'b00 || amt_abs < WIDTH
                                || data_out == '0);
        p_lsl_low_r1:   assert (op_code != 3'b000 || amt_i <= 0 || data_out[0] == 1'b0);
        p_lsr_high_r2:  assert (op_code != 3'b001 || amt_i <= 0
                                || data_out[WIDTH-1] == 1'b0);
        p_asr_sign_r4:  assert (op_code != 3'b011 || amt_i <= 0
                                || data_out[WIDTH-1] == data_in[WIDTH-1]);
        p_asl_fill_r3:  assert (op_code != 3'b010 || amt_i <= 0
                                || data_out[0] == data_in[0]);
        p_neg_asl_r7:   assert (op_code != 3'b010 || amt_i >= 0
                                || data_out[WIDTH-1] == data_in[WIDTH-1]);
    end

endmodule

bind shf_unit shf_unit_chk #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_chk (
    .data_in   (data_in),
    .op_code   (op_code),
    .shift_amt (shift_amt),
    .data_out  (data_out)
);

// File: tb/tb_shf_unit.sv
`timescale 1ns/1ps
module tb_shf_unit;

    localparam int N    = 7;
    localparam int AW   = 5;
    localparam int MASK = (1 << N) - 1;

    logic                 clk = 1'b0;
    logic [N-1:0]         data_in = '0;
    logic [2:0]           op_code = '0;
    logic signed [AW-1:0] shift_amt = '0;
    logic [N-1:0]         data_out;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    shf_unit #(.WIDTH(N), .AMT_W(AW)) dut (
        .data_in   (data_in),
        .op_code   (op_code),
        .shift_amt (shift_amt),
        .data_out  (data_out)
    );

    function automatic int ref_model(int d, int op, int amt);
        int  m;
        int  kind;
        bit  right;
        int  r;
        kind  = op / 2;
        right = (op % 2) == 1;
        if (kind == 3 || amt == 0) return d;
        if (amt < 0) begin
            right = !right;
            m = -amt;
        end else begin
            m = amt;
        end
        if (kind == 2) begin
            r = m % N;
            if (r == 0) return d;
            if (right) return ((d >> r) | (d << (N - r))) & MASK;
            return ((d << r) | (d >> (N - r))) & MASK;
        end
        if (m >= N) begin
            if (kind == 1 && right && d[N-1]) return MASK;
            if (kind == 1 && !right && d[0]) return MASK;
            return 0;
        end
        if (right) begin
            if (kind == 1 && d[N-1]) return ((d >> m) | (MASK & ~(MASK >> m))) & MASK;
            return d >> m;
        end
        if (kind == 1 && d[0]) return ((d << m) | ((1 << m) - 1)) & MASK;
        return (d << m) & MASK;
    endfunction

    function automatic string tag_of(int op, int amt);
        int m;
        m = (amt < 0) ? -amt : amt;
        if (op >= 6) return "R11";
        if (amt == 0) return "R10";
        if (amt < 0) return "R7";
        if (op < 4 && m >= N) return "R8";
        if (op >= 4 && m >= N) return "R9";
        case (op)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic apply_check(input int d, input int op, input int amt,
                               input int exp, input string tag);
        @(posedge clk);
        data_in   = N'(d);
        op_code   = 3'(op);
        shift_amt = AW'(amt);
        @(negedge clk);
        n_checks++;
        if (int'(data_out) != exp) begin
            n_fail++;
            $display("FAIL %s: d=%b op=%0d amt=%0d actual=%b expected=%b",
                     tag, N'(d), op, amt, data_out, N'(exp));
        end
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        // Worked examples on 1001010 as fixed literals
        apply_check('b1001010, 0, 2, 'b0101000, "R1");
        apply_check('b1001010, 1, 4, 'b0000100, "R2");
        apply_check('b1001010, 2, 2, 'b0101000, "R3");
        apply_check('b1001011, 2, 2, 'b0101111, "R3");
        apply_check('b1001010, 3, 4, 'b1111100, "R4");
        apply_check('b1001010, 4, 2, 'b0101010, "R5");
        apply_check('b1001010, 5, 1, 'b0100101, "R6");
        apply_check('b1001010, 4, -1, 'b0100101, "R7");
        apply_check('b1001010, 2, -2, 'b1110010, "R7");
        apply_check('b1001011, 2, 7, 'b1111111, "R8");
        apply_check('b1001010, 4, 9, 'b0101010, "R9");
        apply_check('b1001010, 3, 0, 'b1001010, "R10");
        apply_check('b1001010, 7, 5, 'b1001010, "R11");
        // Exhaustive sweep against the behavioural model
        for (int op = 0; op < 8; op++) begin
            for (int amt = -16; amt < 16; amt++) begin
                for (int d = 0; d <= MASK; d++) begin
                    apply_check(d, op, amt, ref_model(d, op, amt), tag_of(op, amt));
                end
            end
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule